// File: doc/BRIEF.md
# Receive Packet Queue with Separate Length Queue

This block sits between a receive MAC and a processor that fetches frames through a 32-bit register port. The MAC hands over one byte per cycle with a last-byte marker and a 16-bit status word. Bytes are packed into 32-bit words in a data FIFO. When a frame ends, one entry with its byte length and status goes into a second, shallower length queue. The processor learns how many whole frames are waiting from the upper half of a count register. It pops one length entry and then pops ceil(length/4) data words.

Words of a frame under construction are written at a speculative pointer. They become visible only when the frame is committed at its last byte. A frame that does not fit is rolled back whole and a sticky drop flag records which queue lacked room. The length queue's occupancy is compared against a programmable threshold to raise a receive-ready request. Either drop flag raises an error request. A flush control bit empties both queues for as long as it is held.

Register map (word address on `cpu_addr`): 0 data pop, 1 length pop, 2 count, 3 threshold (read/write), 4 control (read/write), 5 drop flags.

Top module: `rxq_top`

## Requirements
- R1: After reset both queues are empty, the count register reads 0, the flags read 0, and both interrupt requests are low.
- R2: Bytes are packed little-endian, with the first byte of each group of four in bits 7:0. A frame of N bytes occupies ceil(N/4) words, and the unused upper bytes of its last word are zero.
- R3: A length entry carries the frame's byte count in bits 15:0 and the status word given with its last byte in bits 31:16, unchanged (for example 0xDF18, the set of error bits).
- R4: The count register holds the number of complete frames in bits 31:16 and the committed data words in bits 15:0. A frame adds to both in the cycle after its last byte and never before.
- R5: A read of address 1 pops one length entry. A read while the queue is empty returns 0 and leaves the count at 0.
- R6: A read of address 0 pops one data word. A read while no committed word exists returns 0.
- R7: `irq_rdy` is high exactly when the number of waiting frames is at least the threshold register (address 3, bits 15:0, reset value 6).
- R8: A frame that ends while the length queue holds LQ_DEPTH entries is discarded whole. Flag bit 0 (address 5) is set and `irq_err` goes high.
- R9: A frame whose words exceed the free data space is discarded whole, and flag bit 1 is set. Frames queued earlier are unchanged, and a later frame that fits is accepted.
- R10: While control bit 0 (address 4) is set, both queues are emptied, the flags are cleared and incoming bytes are ignored. The rest of a frame that was in progress when the flush began is also discarded up to its last byte.
- R11: Frames and their words are read back in arrival order, including when frames arrive on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Receive byte valid |
| rx_dat | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_stat | input | 16 | Frame status, sampled with the final byte |
| cpu_rd | input | 1 | Register read strobe (pops for addresses 0 and 1) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register word address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational from the address |
| irq_rdy | output | 1 | Frame count at or above threshold |
| irq_err | output | 1 | A drop flag is set |

## Verification
The assertions assume that a frame is at least one byte long and never reaches 65536 bytes. They also assume that `cpu_rd` and `cpu_wr` are never high in the same cycle. The stimulus keeps to this: every frame is 1 to 200 bytes, and each register access is a one-cycle strobe issued by a single task at a time. The bench also holds `rx_vld` low while it performs register accesses, except in the flush scenario, where bytes are deliberately sent while the flush is held.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_LEN   = 3'd1;
  localparam logic [2:0] A_COUNT = 3'd2;
  localparam logic [2:0] A_THR   = 3'd3;
  localparam logic [2:0] A_CTRL  = 3'd4;
  localparam logic [2:0] A_FLAGS = 3'd5;

  typedef struct packed {
    logic [15:0] stat;
    logic [15:0] len;
  } rxq_entry_t;

endpackage

// File: rtl/rxq_packer.sv
module rxq_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        in_vld,
  input  logic [7:0]  in_dat,
  input  logic        in_last,
  input  logic [15:0] in_stat,
  output logic        wr_vld,
  output logic [31:0] wr_dat,
  output logic        fin,
  output logic [15:0] fin_len,
  output logic [15:0] fin_stat
);

  logic [1:0]  lane_q, lane_d;
  logic [23:0] acc_q, acc_d;
  logic [15:0] len_q, len_d;
  logic        infr_q, infr_d;
  logic        skip_q, skip_d;
  logic        take;

  assign take     = in_vld && !flush && !skip_q;
  assign wr_vld   = take && (in_last || lane_q == 2'd3);
  assign fin      = take && in_last;
  assign fin_len  = len_q + 16'd1;
  assign fin_stat = in_stat;

  always_comb begin
    case (lane_q)
      2'd0:    wr_dat = {24'd0, in_dat};
      2'd1:    wr_dat = {16'd0, in_dat, acc_q[7:0]};
      2'd2:    wr_dat = {8'd0, in_dat, acc_q[15:0]};
      default: wr_dat = {in_dat, acc_q[23:0]};
    endcase
  end

  always_comb begin
    infr_d = in_vld ? !in_last : infr_q;
    skip_d = skip_q;
    lane_d = lane_q;
    acc_d  = acc_q;
    len_d  = len_q;
    if (flush) begin
      skip_d = infr_d;
      lane_d = 2'd0;
      acc_d  = 24'd0;
      len_d  = 16'd0;
    end else begin
      if (skip_q && in_vld && in_last) begin
        skip_d = 1'b0;
      end
      if (take) begin
        if (in_last || lane_q == 2'd3) begin
          lane_d = 2'd0;
          acc_d  = 24'd0;
        end else begin
          lane_d = lane_q + 2'd1;
          acc_d  = wr_dat[23:0];
        end
        len_d = in_last ? 16'd0 : len_q + 16'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= 2'd0;
      acc_q  <= 24'd0;
      len_q  <= 16'd0;
      infr_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      lane_q <= lane_d;
      acc_q  <= acc_d;
      len_q  <= len_d;
      infr_q <= infr_d;
      skip_q <= skip_d;
    end
  end

endmodule

// File: rtl/rxq_dfifo.sv
module rxq_dfifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_vld,
  input  logic [31:0]   wr_dat,
  input  logic          fin,
  input  logic          accept,
  input  logic          rd_pop,
  output logic [31:0]   rd_dat,
  output logic [PW-1:0] words,
  output logic          frame_ovf
);

  localparam logic [PW-1:0] FULLV = PW'(DEPTH);

  logic [31:0]   mem_q [DEPTH];
  logic [PW-1:0] rptr_q, rptr_d;
  logic [PW-1:0] cptr_q, cptr_d;
  logic [PW-1:0] sptr_q, sptr_d;
  logic          ovf_q, ovf_d;
  logic          spec_full, we, has, pop;
  logic [PW-1:0] sptr_wr;

  assign spec_full = (sptr_q - rptr_q) == FULLV;
  assign we        = wr_vld && !ovf_q && !spec_full && !flush;
  assign frame_ovf = ovf_q || (wr_vld && spec_full);
  assign words     = cptr_q - rptr_q;
  assign has       = words != '0;
  assign pop       = rd_pop && has;
  assign rd_dat    = has ? mem_q[rptr_q[AW-1:0]] : 32'd0;
  assign sptr_wr   = sptr_q + PW'(we);

  always_comb begin
    rptr_d = rptr_q;
    cptr_d = cptr_q;
    sptr_d = sptr_q;
    ovf_d  = ovf_q;
    if (flush) begin
      rptr_d = '0;
      cptr_d = '0;
      sptr_d = '0;
      ovf_d  = 1'b0;
    end else begin
      if (pop) begin
        rptr_d = rptr_q + PW'(1);
      end
      if (fin) begin
        ovf_d = 1'b0;
        if (accept) begin
          cptr_d = sptr_wr;
          sptr_d = sptr_wr;
        end else begin
          sptr_d = cptr_q;
        end
      end else begin
        sptr_d = sptr_wr;
        ovf_d  = frame_ovf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      cptr_q <= '0;
      sptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      rptr_q <= rptr_d;
      cptr_q <= cptr_d;
      sptr_q <= sptr_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[sptr_q[AW-1:0]] <= wr_dat;
    end
  end

endmodule

// File: rtl/rxq_lfifo.sv
module rxq_lfifo #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [31:0]   push_dat,
  input  logic          pop_req,
  output logic [31:0]   head,
  output logic [PW-1:0] cnt,
  output logic          full
);

  localparam logic [PW-1:0] FULLV = PW'(DEPTH);

  logic [31:0]   mem_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] rptr_q, rptr_d;
  logic          has, pop, we;

  assign cnt  = wptr_q - rptr_q;
  assign full = cnt == FULLV;
  assign has  = cnt != '0;
  assign pop  = pop_req && has;
  assign we   = push && !full && !flush;
  assign head = has ? mem_q[rptr_q[AW-1:0]] : 32'd0;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (we) wptr_d = wptr_q + PW'(1);
      if (pop) rptr_d = rptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[wptr_q[AW-1:0]] <= push_dat;
    end
  end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DATA_DEPTH = 64,
  parameter int LQ_DEPTH   = 8,
  parameter int THR_RESET  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_vld,
  input  logic [7:0]  rx_dat,
  input  logic        rx_last,
  input  logic [15:0] rx_stat,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [2:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        irq_rdy,
  output logic        irq_err
);

  localparam int DPW = $clog2(DATA_DEPTH) + 1;
  localparam int LPW = $clog2(LQ_DEPTH) + 1;

  logic [15:0]    thr_q, thr_d;
  logic           flush_q, flush_d;
  logic [1:0]     flg_q, flg_d;

  logic           pk_wr_vld, pk_fin;
  logic [31:0]    pk_wr_dat;
  logic [15:0]    pk_len, pk_stat;
  logic [31:0]    dat_head;
  logic [DPW-1:0] dat_words;
  logic           dat_ovf;
  logic [31:0]    lq_head;
  logic [LPW-1:0] lq_cnt;
  logic           lq_full;
  logic           accept, lq_push, dat_pop, lq_pop;
  rxq_entry_t     ent;
  logic           unused_wbits;

  assign unused_wbits = ^cpu_wdata[31:16];

  assign accept  = !dat_ovf && !lq_full;
  assign lq_push = pk_fin && accept;
  assign dat_pop = cpu_rd && cpu_addr == A_DATA;
  assign lq_pop  = cpu_rd && cpu_addr == A_LEN;
  assign ent.len  = pk_len;
  assign ent.stat = pk_stat;

  rxq_packer u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_q),
    .in_vld   (rx_vld),
    .in_dat   (rx_dat),
    .in_last  (rx_last),
    .in_stat  (rx_stat),
    .wr_vld   (pk_wr_vld),
    .wr_dat   (pk_wr_dat),
    .fin      (pk_fin),
    .fin_len  (pk_len),
    .fin_stat (pk_stat)
  );

  rxq_dfifo #(.DEPTH(DATA_DEPTH)) u_dfifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_q),
    .wr_vld    (pk_wr_vld),
    .wr_dat    (pk_wr_dat),
    .fin       (pk_fin),
    .accept    (accept),
    .rd_pop    (dat_pop),
    .rd_dat    (dat_head),
    .words     (dat_words),
    .frame_ovf (dat_ovf)
  );

  rxq_lfifo #(.DEPTH(LQ_DEPTH)) u_lfifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_q),
    .push     (lq_push),
    .push_dat (ent),
    .pop_req  (lq_pop),
    .head     (lq_head),
    .cnt      (lq_cnt),
    .full     (lq_full)
  );

  always_comb begin
    thr_d   = thr_q;
    flush_d = flush_q;
    flg_d   = flg_q;
    if (cpu_wr && cpu_addr == A_THR) thr_d = cpu_wdata[15:0];
    if (cpu_wr && cpu_addr == A_CTRL) flush_d = cpu_wdata[0];
    if (flush_q) begin
      flg_d = 2'b00;
    end else if (pk_fin) begin
      flg_d = flg_q | {dat_ovf, lq_full};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= 16'(THR_RESET);
      flush_q <= 1'b0;
      flg_q   <= 2'b00;
    end else begin
      thr_q   <= thr_d;
      flush_q <= flush_d;
      flg_q   <= flg_d;
    end
  end

  always_comb begin
    case (cpu_addr)
      A_DATA:  cpu_rdata = dat_head;
      A_LEN:   cpu_rdata = lq_head;
      A_COUNT: cpu_rdata = {16'(lq_cnt), 16'(dat_words)};
      A_THR:   cpu_rdata = {16'd0, thr_q};
      A_CTRL:  cpu_rdata = {31'd0, flush_q};
      A_FLAGS: cpu_rdata = {30'd0, flg_q};
      default: cpu_rdata = 32'd0;
    endcase
  end

  assign irq_rdy = 16'(lq_cnt) >= thr_q;
  assign irq_err = |flg_q;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DATA_DEPTH = 64,
  parameter int LQ_DEPTH   = 8,
  localparam int DPW = $clog2(DATA_DEPTH) + 1,
  localparam int LPW = $clog2(LQ_DEPTH) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush_q,
  input logic [LPW-1:0] lq_cnt,
  input logic [DPW-1:0] dat_words,
  input logic           pk_fin,
  input logic           lq_full,
  input logic [1:0]     flg_q,
  input logic           cpu_rd,
  input logic [2:0]     cpu_addr,
  input logic [31:0]    cpu_rdata
);

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> (lq_cnt == '0 && dat_words == '0 && flg_q == 2'b00));

  // R8
  lq_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_fin && lq_full && !flush_q) |=> flg_q[0]);

  // R8
  lq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(lq_cnt) <= LQ_DEPTH);

  // R9
  words_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(dat_words) <= DATA_DEPTH);

  // R4
  pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_cnt > $past(lq_cnt)) |-> (lq_cnt == $past(lq_cnt) + 1'b1));

  // R5
  empty_len_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == 3'd1 && lq_cnt == '0) |-> cpu_rdata == 32'd0);

  // R6
  empty_data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == 3'd0 && dat_words == '0) |-> cpu_rdata == 32'd0);

endmodule

bind rxq_top rxq_chk #(.DATA_DEPTH(DATA_DEPTH), .LQ_DEPTH(LQ_DEPTH)) u_rxq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_q   (flush_q),
  .lq_cnt    (lq_cnt),
  .dat_words (dat_words),
  .pk_fin    (pk_fin),
  .lq_full   (lq_full),
  .flg_q     (flg_q),
  .cpu_rd    (cpu_rd),
  .cpu_addr  (cpu_addr),
  .cpu_rdata (cpu_rdata)
);

// File: tb/test_rxq_top.sv
`timescale 1ns/1ps
module test_rxq_top;

  logic        clk;
  logic        rst_n;
  logic        rx_vld;
  logic [7:0]  rx_dat;
  logic        rx_last;
  logic [15:0] rx_stat;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [2:0]  cpu_addr;
  logic [31:0] cpu_wdata;
  logic [31:0] cpu_rdata;
  logic        irq_rdy;
  logic        irq_err;

  int checks;
  int errors;
  bit done;

  rxq_top i_rxq_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_vld    (rx_vld),
    .rx_dat    (rx_dat),
    .rx_last   (rx_last),
    .rx_stat   (rx_stat),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .irq_rdy   (irq_rdy),
    .irq_err   (irq_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [31:0] d);
    cpu_rd   = 1'b1;
    cpu_addr = a;
    #1;
    d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [31:0] d);
    cpu_wr    = 1'b1;
    cpu_addr  = a;
    cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // Sends n bytes valued first, first+1, ...; the final one marked last if req'd.
  task automatic send_bytes(input logic [7:0] first, input int n, input bit with_last,
                            input logic [15:0] st);
    for (int i = 0; i < n; i++) begin
      rx_vld  = 1'b1;
      rx_dat  = first + 8'(i);
      rx_last = with_last && (i == n - 1);
      rx_stat = st;
      @(negedge clk);
    end
    rx_vld  = 1'b0;
    rx_last = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] first, input int n, input int j);
    logic [31:0] w;
    w = 32'd0;
    for (int b = 0; b < 4; b++) begin
      if (4 * j + b < n) w[8*b +: 8] = first + 8'(4 * j + b);
    end
    return w;
  endfunction

  task automatic drain_frame(input string tag, input logic [7:0] first, input int n,
                             input logic [15:0] st);
    logic [31:0] d;
    cpu_read(3'd1, d);
    check({tag, " len entry"}, d, {st, 16'(n)});
    for (int j = 0; j < (n + 3) / 4; j++) begin
      cpu_read(3'd0, d);
      check({tag, " data word"}, d, exp_word(first, n, j));
    end
  endtask

  task automatic do_flush();
    cpu_write(3'd4, 32'd1);
    @(negedge clk);
    cpu_write(3'd4, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    cpu_read(3'd2, d);
    check("R1 count after reset", d, 32'd0);
    cpu_read(3'd5, d);
    check("R1 flags after reset", d, 32'd0);
    check("R1 irq_rdy after reset", {31'd0, irq_rdy}, 32'd0);
    check("R1 irq_err after reset", {31'd0, irq_err}, 32'd0);
    cpu_read(3'd1, d);
    check("R5 empty length read", d, 32'd0);
    cpu_read(3'd0, d);
    check("R6 empty data read", d, 32'd0);
    cpu_read(3'd2, d);
    check("R5 count after empty reads", d, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    send_bytes(8'h10, 5, 1'b0, 16'hDF18);
    cpu_read(3'd2, d);
    check("R4 nothing visible mid-frame", d, 32'd0);
    send_bytes(8'h15, 1, 1'b1, 16'hDF18);
    cpu_read(3'd2, d);
    check("R4 count after one frame", d, {16'd1, 16'd2});
    drain_frame("R2 R3 basic", 8'h10, 6, 16'hDF18);
    cpu_read(3'd2, d);
    check("R5 count after drain", d, 32'd0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    send_bytes(8'h40, 4, 1'b1, 16'h0001);
    send_bytes(8'h50, 1, 1'b1, 16'h0002);
    send_bytes(8'h60, 7, 1'b1, 16'h0003);
    cpu_read(3'd2, d);
    check("R11 count after three frames", d, {16'd3, 16'd4});
    drain_frame("R11 frame a", 8'h40, 4, 16'h0001);
    drain_frame("R11 frame b", 8'h50, 1, 16'h0002);
    drain_frame("R11 frame c", 8'h60, 7, 16'h0003);
  endtask

  task automatic t_irq();
    cpu_write(3'd3, 32'd3);
    send_bytes(8'h01, 2, 1'b1, 16'h0);
    send_bytes(8'h02, 2, 1'b1, 16'h0);
    check("R7 irq_rdy below threshold", {31'd0, irq_rdy}, 32'd0);
    send_bytes(8'h03, 2, 1'b1, 16'h0);
    check("R7 irq_rdy at threshold", {31'd0, irq_rdy}, 32'd1);
    drain_frame("R7 drain", 8'h01, 2, 16'h0);
    check("R7 irq_rdy after pop", {31'd0, irq_rdy}, 32'd0);
    do_flush();
    cpu_write(3'd3, 32'd15);
  endtask

  task automatic t_lq_full();
    logic [31:0] d;
    for (int i = 0; i < 9; i++) send_bytes(8'(8'h80 + i), 1, 1'b1, 16'(i));
    cpu_read(3'd2, d);
    check("R8 count with full length queue", d, {16'd8, 16'd8});
    cpu_read(3'd5, d);
    check("R8 length drop flag", d, 32'd1);
    check("R8 irq_err raised", {31'd0, irq_err}, 32'd1);
    for (int i = 0; i < 8; i++) drain_frame("R8 kept frame", 8'(8'h80 + i), 1, 16'(i));
    cpu_read(3'd1, d);
    check("R8 dropped frame absent", d, 32'd0);
    do_flush();
    cpu_read(3'd5, d);
    check("R10 flags cleared by flush", d, 32'd0);
  endtask

  task automatic t_data_full();
    logic [31:0] d;
    send_bytes(8'h00, 200, 1'b1, 16'h0A0A);
    send_bytes(8'h20, 80, 1'b1, 16'h0B0B);
    cpu_read(3'd5, d);
    check("R9 data drop flag", d, 32'd2);
    cpu_read(3'd2, d);
    check("R9 count after drop", d, {16'd1, 16'd50});
    send_bytes(8'h90, 40, 1'b1, 16'h0C0C);
    cpu_read(3'd2, d);
    check("R9 later frame accepted", d, {16'd2, 16'd60});
    drain_frame("R9 earlier frame intact", 8'h00, 200, 16'h0A0A);
    drain_frame("R9 later frame", 8'h90, 40, 16'h0C0C);
    do_flush();
  endtask

  task automatic t_flush();
    logic [31:0] d;
    send_bytes(8'h30, 3, 1'b1, 16'h0);
    send_bytes(8'hA0, 3, 1'b0, 16'h0);
    cpu_write(3'd4, 32'd1);
    @(negedge clk);
    cpu_read(3'd2, d);
    check("R10 count while flushing", d, 32'd0);
    send_bytes(8'hA3, 2, 1'b0, 16'h0);
    cpu_write(3'd4, 32'd0);
    send_bytes(8'hA5, 3, 1'b1, 16'h7777);
    cpu_read(3'd2, d);
    check("R10 tail of flushed frame ignored", d, 32'd0);
    send_bytes(8'hC0, 5, 1'b1, 16'h1234);
    cpu_read(3'd2, d);
    check("R10 frame after flush accepted", d, {16'd1, 16'd2});
    drain_frame("R10 post-flush frame", 8'hC0, 5, 16'h1234);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    rx_vld    = 1'b0;
    rx_dat    = 8'd0;
    rx_last   = 1'b0;
    rx_stat   = 16'd0;
    cpu_rd    = 1'b0;
    cpu_wr    = 1'b0;
    cpu_addr  = 3'd0;
    cpu_wdata = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_irq();
    t_lq_full();
    t_data_full();
    t_flush();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule